// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This block takes a trap request and decides in one step which handler takes it: supervisor or machine. In the same clock edge it writes that handler's state. The handler state is the next program counter, the cause, the exception PC, an optional faulting address, the interrupt-stack fields of the status word and the new privilege level. Each trap also raises two one-cycle pulses. One drops any outstanding load reservation and the other asks for a translation-cache flush.

The cause word tells interrupts from exceptions by its top bit, and each class has its own delegation mask. A trap is passed down to supervisor only when three things hold: it came from user or supervisor privilege, its stripped cause index fits inside the register width, and the matching mask bit is set. Any other trap goes to machine. On entry, the previous-enable bit is copied from the enable bit that belongs to the privilege the trap came from.

Top module: `trap_entry_unit`

## Requirements
- R1: When trap cause bit XLEN-1 is 1, the interrupt delegation mask is consulted; otherwise the exception mask is. The mask bit is indexed by the cause with bit XLEN-1 removed.
- R2: Privilege encoding is user=0, supervisor=1, reserved=2, machine=3. A trap goes to supervisor only if privIn<=1, the stripped index is below XLEN and the selected mask bit is 1. Every other trap, including one from privilege 2, goes to machine (privOut=3).
- R3: On supervisor entry, nextPc takes sVector, sCause takes the cause and sEpc takes the exception PC. mCause, mEpc and mBadAddr keep their values.
- R4: sBadAddr or mBadAddr (whichever belongs to the target) is loaded from badAddr only when badAddrValid is 1. Otherwise both keep their values.
- R5: On supervisor entry, statusOut equals statusIn with three changes. Bit 5 takes statusIn bit privIn, bit 8 takes privIn bit 0 and bit 1 is cleared. privOut becomes 1.
- R6: On machine entry, nextPc takes mVector, and mCause and mEpc are loaded while sCause, sEpc and sBadAddr keep their values. statusOut equals statusIn with three changes: bit 7 takes statusIn bit privIn, bits 12:11 take privIn and bit 3 is cleared. privOut becomes 3.
- R7: resvClear and tlbFlush are both high during the cycle after every clock edge where trapReq is high, and low after any edge where it is low.
- R8: While trapReq is low, all registered outputs hold, whatever the other inputs do.
- R9: When rstN is low, all address, cause and status outputs read 0, privOut reads 3 and both pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trapReq | input | 1 | Take a trap on this edge |
| trapCause | input | XLEN | Cause; top bit marks an interrupt |
| trapEpc | input | XLEN | PC of the trapping instruction |
| badAddr | input | XLEN | Faulting address |
| badAddrValid | input | 1 | badAddr is supplied |
| excDeleg | input | XLEN | Exception delegation mask |
| intDeleg | input | XLEN | Interrupt delegation mask |
| sVector | input | XLEN | Supervisor handler address |
| mVector | input | XLEN | Machine handler address |
| statusIn | input | XLEN | Current status word |
| privIn | input | 2 | Current privilege |
| nextPc | output | XLEN | Handler address after the trap |
| sCause | output | XLEN | Supervisor cause register |
| sEpc | output | XLEN | Supervisor exception PC |
| sBadAddr | output | XLEN | Supervisor faulting address |
| mCause | output | XLEN | Machine cause register |
| mEpc | output | XLEN | Machine exception PC |
| mBadAddr | output | XLEN | Machine faulting address |
| statusOut | output | XLEN | Status word after the trap |
| privOut | output | 2 | Privilege after the trap |
| resvClear | output | 1 | Load-reservation clear pulse |
| tlbFlush | output | 1 | Translation-cache flush request pulse |

## Verification
The bench builds the unit with XLEN=32, so a cause index of 37 lands outside the mask and has to be routed to machine even though the mask is all ones. The same width lets the masks be mixed so that only the interrupt bit decides which mask applies. The two-bit privilege input is also driven to the reserved value 2. That shows a trap from it goes to machine and stacks status bit 2 as the previous enable. Back-to-back traps and a long hold with churning inputs cover the pulse and hold rules.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam int SIE_POS  = 1;
  localparam int MIE_POS  = 3;
  localparam int SPIE_POS = 5;
  localparam int MPIE_POS = 7;
  localparam int SPP_POS  = 8;
  localparam int MPP_LO   = 11;

  typedef struct packed {
    logic takeS;
    logic takeM;
    logic loadBad;
  } trap_strobe_t;
endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            trapReq,
  input  logic [XLEN-1:0] trapCause,
  input  logic [XLEN-1:0] excDeleg,
  input  logic [XLEN-1:0] intDeleg,
  input  logic [1:0]      privIn,
  input  logic            badAddrValid,
  output trap_strobe_t    strobe
);
  localparam int IDXW = $clog2(XLEN);

  logic [XLEN-2:0] causeIdx;
  logic [XLEN-1:0] activeMask;
  logic            idxInRange;
  logic            maskBit;
  logic            privLowEnough;
  logic            toSup;

  always_comb begin
    causeIdx      = trapCause[XLEN-2:0];
    activeMask    = trapCause[XLEN-1] ? intDeleg : excDeleg;
    idxInRange    = ~|causeIdx[XLEN-2:IDXW];
    maskBit       = activeMask[causeIdx[IDXW-1:0]];
    privLowEnough = (privIn <= PRIV_S);
    toSup         = privLowEnough && idxInRange && maskBit;
  end

  always_comb begin
    strobe.takeS   = trapReq && toSup;
    strobe.takeM   = trapReq && !toSup;
    strobe.loadBad = trapReq && badAddrValid;
  end
endmodule

// File: rtl/trap_bank.sv
module trap_bank #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            take,
  input  logic            loadBad,
  input  logic [XLEN-1:0] causeIn,
  input  logic [XLEN-1:0] epcIn,
  input  logic [XLEN-1:0] badIn,
  output logic [XLEN-1:0] causeQ,
  output logic [XLEN-1:0] epcQ,
  output logic [XLEN-1:0] badQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      causeQ <= '0;
      epcQ   <= '0;
      badQ   <= '0;
    end else if (take) begin
      causeQ <= causeIn;
      epcQ   <= epcIn;
      if (loadBad) badQ <= badIn;
    end
  end
endmodule

// File: rtl/trap_dpath.sv
module trap_dpath
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  trap_strobe_t    strobe,
  input  logic [XLEN-1:0] trapCause,
  input  logic [XLEN-1:0] trapEpc,
  input  logic [XLEN-1:0] badAddr,
  input  logic [XLEN-1:0] sVector,
  input  logic [XLEN-1:0] mVector,
  input  logic [XLEN-1:0] statusIn,
  input  logic [1:0]      privIn,
  output logic [XLEN-1:0] nextPc,
  output logic [XLEN-1:0] sCause,
  output logic [XLEN-1:0] sEpc,
  output logic [XLEN-1:0] sBadAddr,
  output logic [XLEN-1:0] mCause,
  output logic [XLEN-1:0] mEpc,
  output logic [XLEN-1:0] mBadAddr,
  output logic [XLEN-1:0] statusOut,
  output logic [1:0]      privOut,
  output logic            resvClear,
  output logic            tlbFlush
);
  localparam int NBANK = 2;

  logic [XLEN-1:0] bankCause [NBANK];
  logic [XLEN-1:0] bankEpc   [NBANK];
  logic [XLEN-1:0] bankBad   [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic bankTake;
    assign bankTake = (g == 0) ? strobe.takeS : strobe.takeM;
    trap_bank #(.XLEN(XLEN)) u_bank (
      .clk    (clk),
      .rstN   (rstN),
      .take   (bankTake),
      .loadBad(strobe.loadBad),
      .causeIn(trapCause),
      .epcIn  (trapEpc),
      .badIn  (badAddr),
      .causeQ (bankCause[g]),
      .epcQ   (bankEpc[g]),
      .badQ   (bankBad[g])
    );
  end

  assign sCause   = bankCause[0];
  assign sEpc     = bankEpc[0];
  assign sBadAddr = bankBad[0];
  assign mCause   = bankCause[1];
  assign mEpc     = bankEpc[1];
  assign mBadAddr = bankBad[1];

  logic            prevEnable;
  logic [XLEN-1:0] supStatus;
  logic [XLEN-1:0] machStatus;

  always_comb begin
    prevEnable = statusIn[privIn];
    supStatus  = statusIn;
    supStatus[SPIE_POS] = prevEnable;
    supStatus[SPP_POS]  = privIn[0];
    supStatus[SIE_POS]  = 1'b0;
    machStatus = statusIn;
    machStatus[MPIE_POS]         = prevEnable;
    machStatus[MPP_LO+1:MPP_LO]  = privIn;
    machStatus[MIE_POS]          = 1'b0;
  end

  logic trapTaken;
  assign trapTaken = strobe.takeS | strobe.takeM;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nextPc    <= '0;
      statusOut <= '0;
      privOut   <= PRIV_M;
      resvClear <= 1'b0;
      tlbFlush  <= 1'b0;
    end else begin
      resvClear <= trapTaken;
      tlbFlush  <= trapTaken;
      if (strobe.takeS) begin
        nextPc    <= sVector;
        statusOut <= supStatus;
        privOut   <= PRIV_S;
      end else if (strobe.takeM) begin
        nextPc    <= mVector;
        statusOut <= machStatus;
        privOut   <= PRIV_M;
      end
    end
  end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            trapReq,
  input  logic [XLEN-1:0] trapCause,
  input  logic [XLEN-1:0] trapEpc,
  input  logic [XLEN-1:0] badAddr,
  input  logic            badAddrValid,
  input  logic [XLEN-1:0] excDeleg,
  input  logic [XLEN-1:0] intDeleg,
  input  logic [XLEN-1:0] sVector,
  input  logic [XLEN-1:0] mVector,
  input  logic [XLEN-1:0] statusIn,
  input  logic [1:0]      privIn,
  output logic [XLEN-1:0] nextPc,
  output logic [XLEN-1:0] sCause,
  output logic [XLEN-1:0] sEpc,
  output logic [XLEN-1:0] sBadAddr,
  output logic [XLEN-1:0] mCause,
  output logic [XLEN-1:0] mEpc,
  output logic [XLEN-1:0] mBadAddr,
  output logic [XLEN-1:0] statusOut,
  output logic [1:0]      privOut,
  output logic            resvClear,
  output logic            tlbFlush
);
  trap_strobe_t strobe;

  trap_ctrl #(.XLEN(XLEN)) u_ctrl (
    .trapReq     (trapReq),
    .trapCause   (trapCause),
    .excDeleg    (excDeleg),
    .intDeleg    (intDeleg),
    .privIn      (privIn),
    .badAddrValid(badAddrValid),
    .strobe      (strobe)
  );

  trap_dpath #(.XLEN(XLEN)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .trapCause(trapCause),
    .trapEpc  (trapEpc),
    .badAddr  (badAddr),
    .sVector  (sVector),
    .mVector  (mVector),
    .statusIn (statusIn),
    .privIn   (privIn),
    .nextPc   (nextPc),
    .sCause   (sCause),
    .sEpc     (sEpc),
    .sBadAddr (sBadAddr),
    .mCause   (mCause),
    .mEpc     (mEpc),
    .mBadAddr (mBadAddr),
    .statusOut(statusOut),
    .privOut  (privOut),
    .resvClear(resvClear),
    .tlbFlush (tlbFlush)
  );
endmodule

// File: rtl/trap_entry_checker.sv
module trap_entry_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            trapReq,
  input logic [XLEN-1:0] trapCause,
  input logic            badAddrValid,
  input logic [XLEN-1:0] intDeleg,
  input logic [XLEN-1:0] sVector,
  input logic [XLEN-1:0] mVector,
  input logic [1:0]      privIn,
  input logic [XLEN-1:0] nextPc,
  input logic [XLEN-1:0] sBadAddr,
  input logic [XLEN-1:0] mBadAddr,
  input logic [XLEN-1:0] statusOut,
  input logic [1:0]      privOut,
  input logic            resvClear,
  input logic            tlbFlush
);
  assert_int_mask_R1: assert property (@(posedge clk) disable iff (!rstN)
    trapReq && trapCause[XLEN-1] && (intDeleg == '0) |=> privOut == 2'd3);

  assert_route_R2: assert property (@(posedge clk) disable iff (!rstN)
    trapReq && (privIn > 2'd1) |=> privOut == 2'd3);

  assert_sup_vector_R3: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |=> (privOut != 2'd1) || (nextPc == $past(sVector)));

  assert_bad_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    trapReq && !badAddrValid |=> $stable(sBadAddr) && $stable(mBadAddr));

  assert_sie_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |=> (privOut != 2'd1) || !statusOut[1]);

  assert_mach_entry_R6: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |=> (privOut == 2'd1) ||
                (privOut == 2'd3 && nextPc == $past(mVector) && !statusOut[3]));

  assert_pulse_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |=> resvClear && tlbFlush);

  assert_pulse_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    !trapReq |=> !resvClear && !tlbFlush);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !trapReq |=> $stable(nextPc) && $stable(privOut) && $stable(statusOut));
endmodule

bind trap_entry_unit trap_entry_checker #(.XLEN(XLEN)) u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .trapReq     (trapReq),
  .trapCause   (trapCause),
  .badAddrValid(badAddrValid),
  .intDeleg    (intDeleg),
  .sVector     (sVector),
  .mVector     (mVector),
  .privIn      (privIn),
  .nextPc      (nextPc),
  .sBadAddr    (sBadAddr),
  .mBadAddr    (mBadAddr),
  .statusOut   (statusOut),
  .privOut     (privOut),
  .resvClear   (resvClear),
  .tlbFlush    (tlbFlush)
);

// File: tb/trap_entry_unit_bench.sv
`timescale 1ns/1ps
module trap_entry_unit_bench;
  localparam int XLEN = 32;

  typedef struct packed {
    logic [31:0] cause;
    logic [1:0]  priv;
    logic [31:0] exc;
    logic [31:0] intd;
    logic [31:0] status;
    logic        badV;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_0002, 2'd0, 32'h0000_0004, 32'h0000_0000, 32'h0000_0001, 1'b1},
    '{32'h0000_0002, 2'd3, 32'h0000_0004, 32'h0000_0000, 32'h0000_0008, 1'b0},
    '{32'h8000_0005, 2'd1, 32'h0000_0000, 32'h0000_0020, 32'h0000_0002, 1'b1},
    '{32'h8000_0005, 2'd1, 32'h0000_0020, 32'h0000_0000, 32'h0000_0002, 1'b1},
    '{32'h0000_0025, 2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0},
    '{32'h0000_000D, 2'd0, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1},
    '{32'h0000_0008, 2'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0004, 1'b1},
    '{32'h8000_0001, 2'd0, 32'h0000_0000, 32'h0000_0002, 32'h0000_0010, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trapReq = 1'b0;
  logic [XLEN-1:0] trapCause = '0, trapEpc = '0, badAddr = '0;
  logic badAddrValid = 1'b0;
  logic [XLEN-1:0] excDeleg = '0, intDeleg = '0;
  logic [XLEN-1:0] sVector = 32'h0000_1000, mVector = 32'h0000_2000;
  logic [XLEN-1:0] statusIn = '0;
  logic [1:0] privIn = 2'd0;
  logic [XLEN-1:0] nextPc, sCause, sEpc, sBadAddr, mCause, mEpc, mBadAddr, statusOut;
  logic [1:0] privOut;
  logic resvClear, tlbFlush;

  always #2 clk = ~clk;

  trap_entry_unit #(.XLEN(XLEN)) u_trap_entry_unit (.*);

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] eNext, eSC, eSE, eSB, eMC, eME, eMB, eStat;
  logic [1:0]  ePriv;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chkAll(input string tag);
    chk({tag, " R3/R6 nextPc"}, nextPc, eNext);
    chk({tag, " R3 sCause"}, sCause, eSC);
    chk({tag, " R3 sEpc"}, sEpc, eSE);
    chk({tag, " R4 sBadAddr"}, sBadAddr, eSB);
    chk({tag, " R6 mCause"}, mCause, eMC);
    chk({tag, " R6 mEpc"}, mEpc, eME);
    chk({tag, " R4 mBadAddr"}, mBadAddr, eMB);
    chk({tag, " R5/R6 statusOut"}, statusOut, eStat);
    chk({tag, " R2 privOut"}, {30'd0, privOut}, {30'd0, ePriv});
  endtask

  task automatic drive(input vec_t v, input logic [31:0] epc, input logic [31:0] bad);
    logic toS;
    logic [30:0] idx;
    logic [31:0] mask;
    logic ie;
    trapCause = v.cause; privIn = v.priv; excDeleg = v.exc; intDeleg = v.intd;
    statusIn = v.status; badAddrValid = v.badV; trapEpc = epc; badAddr = bad;
    trapReq = 1'b1;
    // R1: top cause bit picks the mask; R2: routing rule
    mask = v.cause[31] ? v.intd : v.exc;
    idx = v.cause[30:0];
    toS = (v.priv <= 2'd1) && (idx < 31'd32) && mask[idx[4:0]];
    ie = v.status[v.priv];
    eStat = v.status;
    if (toS) begin
      eNext = sVector; eSC = v.cause; eSE = epc; if (v.badV) eSB = bad;
      eStat[5] = ie; eStat[8] = v.priv[0]; eStat[1] = 1'b0; ePriv = 2'd1;
    end else begin
      eNext = mVector; eMC = v.cause; eME = epc; if (v.badV) eMB = bad;
      eStat[7] = ie; eStat[12:11] = v.priv; eStat[3] = 1'b0; ePriv = 2'd3;
    end
  endtask

  task automatic resetModel();
    eNext = '0; eSC = '0; eSE = '0; eSB = '0; eMC = '0; eME = '0; eMB = '0;
    eStat = '0; ePriv = 2'd3;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    resetModel();
    repeat (3) @(negedge clk);
    chkAll("reset R9");
    chk("reset R9 resvClear", {31'd0, resvClear}, 32'd0);
    chk("reset R9 tlbFlush", {31'd0, tlbFlush}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i], 32'h0000_4000 + 32'(i * 4), 32'h0000_BAD0 + 32'(i));
      @(posedge clk); @(negedge clk);
      trapReq = 1'b0;
      chkAll($sformatf("vec%0d", i));
      chk($sformatf("vec%0d R7 resvClear high", i), {31'd0, resvClear}, 32'd1);
      chk($sformatf("vec%0d R7 tlbFlush high", i), {31'd0, tlbFlush}, 32'd1);
      @(posedge clk); @(negedge clk);
      chk($sformatf("vec%0d R7 resvClear low", i), {31'd0, resvClear}, 32'd0);
      chk($sformatf("vec%0d R7 tlbFlush low", i), {31'd0, tlbFlush}, 32'd0);
    end

    // R8: churn inputs with no trap request
    trapCause = 32'h8000_0003; trapEpc = 32'hDEAD_0000; badAddr = 32'hFFFF_0000;
    badAddrValid = 1'b1; excDeleg = '1; intDeleg = '1; sVector = 32'h0000_3000;
    mVector = 32'h0000_5000; statusIn = '1; privIn = 2'd1;
    repeat (4) @(negedge clk);
    chkAll("hold R8");
    chk("hold R8 resvClear", {31'd0, resvClear}, 32'd0);

    // R7: back-to-back traps keep the pulses high
    drive(VECS[0], 32'h0000_6000, 32'h0000_6001);
    @(posedge clk); @(negedge clk);
    chk("b2b first R7 resvClear", {31'd0, resvClear}, 32'd1);
    chkAll("b2b first");
    drive(VECS[1], 32'h0000_7000, 32'h0000_7001);
    @(posedge clk); @(negedge clk);
    trapReq = 1'b0;
    chk("b2b second R7 resvClear", {31'd0, resvClear}, 32'd1);
    chk("b2b second R7 tlbFlush", {31'd0, tlbFlush}, 32'd1);
    chkAll("b2b second");

    // R9: reset in the middle of a run
    rstN = 1'b0;
    resetModel();
    #1;
    chkAll("midreset R9");
    chk("midreset R9 tlbFlush", {31'd0, tlbFlush}, 32'd0);
    finish();
  end
endmodule